// File: doc/BRIEF.md
# Stereo PCM Serializer

This block turns a parallel stereo pair of 16-bit PCM samples into a three-line serial audio stream: a bit clock, a left/right word clock and a data line. All logic runs on one system clock. Timing comes from `tick_en`, a one-cycle strobe at 384 times the sample rate. That rate divides evenly into each of the three supported bit-clock ratios, so one frame always spans exactly 384 strobes, whichever ratio is in force.

Run-time inputs select three things: the bit-clock ratio (32, 48 or 64 bit clocks per sample period), the word-clock polarity and the bit order. These inputs are sampled once per frame and take effect from the next frame. Data changes on falling edges of the bit clock, so a receiver samples it on rising edges.

Samples enter through a valid/ready port. `in_ready` is a one-cycle request raised in the last system cycle of each frame. The source cannot hold the block back. If `in_valid` is high in that cycle, the pair on `in_left`/`in_right` is taken and sent in the frame that follows. If it is low, that frame carries silence. A high `in_valid` outside the request cycle is ignored. At most one pair enters per frame.

Top module: `audio_serializer`

## Requirements
- R1: `rate_sel` picks the bit-clock ratio. With encoding 0 the bit clock stays high or low for 6 strobes, and each half-frame has 16 bit slots (32 fs). Encoding 1 gives 4 strobes and 24 slots (48 fs). Encoding 2 gives 3 strobes and 32 slots (64 fs). Encoding 3 behaves as encoding 0.
- R2: During reset and after it, `bck`, `wclk`, `sdata` and `in_ready` are low. The first frame after reset uses 32 fs, no inversion and MSB first, and it carries zeros.
- R3: With `wc_invert` = 0, `wclk` is low for the left half-frame and high for the right half-frame. With `wc_invert` = 1, both levels are swapped.
- R4: With `lsb_first` = 0, slot 0 of each half-frame carries sample bit 15 and later slots carry bits in falling order. With `lsb_first` = 1, slot 0 carries bit 0 and later slots carry bits in rising order.
- R5: In 48 fs and 64 fs mode, slots 16 and above of each half-frame carry zero.
- R6: `sdata` and `wclk` change only on system edges where `bck` goes from high to low.
- R7: The configuration inputs are sampled in the `in_ready` cycle and govern the whole next frame. Changes at any other time have no effect on the frame in progress.
- R8: `in_ready` is high for exactly one system cycle per frame, and frames are 384 strobes long. That cycle is the last one before the left half-frame starts. A pair offered with `in_valid` high in that cycle is sent in the next frame.
- R9: If `in_valid` is low in the `in_ready` cycle, the next frame carries zeros in every slot.
- R10: In a cycle with `tick_en` low, `bck`, `wclk`, `sdata` and the internal position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timing strobe at 384 times the sample rate |
| rate_sel | input | 2 | Bit-clock ratio select (0: 32 fs, 1: 48 fs, 2: 64 fs, 3: 32 fs) |
| wc_invert | input | 1 | Swap word-clock levels |
| lsb_first | input | 1 | Send least significant bit first |
| in_valid | input | 1 | Source offers a stereo pair |
| in_ready | output | 1 | One-cycle request: pair taken at this edge |
| in_left | input | WORD_W | Left sample |
| in_right | input | WORD_W | Right sample |
| bck | output | 1 | Bit clock |
| wclk | output | 1 | Left/right word clock |
| sdata | output | 1 | Serial data |

## Verification
Three things happen on the same system edge: the final falling edge of a frame, the adoption of a new configuration and the handshake for the next pair. The bench changes the configuration at random points within frames, including the request cycle itself. It also leaves `in_valid` low in some request cycles and drops `tick_en` at random during a run of frames, so that a pause can land on the boundary. The bench logs each pair and configuration as the port shows them in the request cycle. It records every bit-clock rising edge, and at the next request it compares the whole recorded frame, together with each high-phase length and the 384-strobe frame length, against what that logged entry predicts.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic [1:0] {
    RATE_32  = 2'd0,
    RATE_48  = 2'd1,
    RATE_64  = 2'd2,
    RATE_ALT = 2'd3
  } rate_e;

  typedef struct packed {
    rate_e rate;
    logic  wc_inv;
    logic  lsb_first;
  } ser_cfg_t;

  localparam int STROBES_PER_FRAME = 384;
  localparam int DIV_W  = 3;
  localparam int SLOT_W = 6;

  // strobes per bit-clock phase
  function automatic logic [DIV_W-1:0] phase_len(rate_e r);
    case (r)
      RATE_48: return DIV_W'(4);
      RATE_64: return DIV_W'(3);
      default: return DIV_W'(6);
    endcase
  endfunction

  // bit slots per half-frame
  function automatic logic [SLOT_W-1:0] half_slots(rate_e r);
    case (r)
      RATE_48: return SLOT_W'(24);
      RATE_64: return SLOT_W'(32);
      default: return SLOT_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/ser_timing.sv
module ser_timing
  import ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  rate_e             rate,
  output logic              bck,
  output logic              lr,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_last
);

  logic [DIV_W-1:0]  div_q;
  logic              bck_q, lr_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DIV_W-1:0]  plen;
  logic [SLOT_W-1:0] nslots;
  logic              phase_end, falling, slot_wrap;

  always_comb begin
    plen      = phase_len(rate);
    nslots    = half_slots(rate);
    phase_end = tick_en && (div_q == plen - DIV_W'(1));
    falling   = phase_end && bck_q;
    slot_wrap = (slot_q == nslots - SLOT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      bck_q  <= 1'b0;
      lr_q   <= 1'b0;
      slot_q <= '0;
    end else if (tick_en) begin
      div_q <= phase_end ? '0 : div_q + DIV_W'(1);
      if (phase_end) bck_q <= ~bck_q;
      if (falling) begin
        if (slot_wrap) begin
          slot_q <= '0;
          lr_q   <= ~lr_q;
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end

  assign bck        = bck_q;
  assign lr         = lr_q;
  assign slot       = slot_q;
  assign frame_last = falling && slot_wrap && lr_q;

  // R10: no strobe, no movement
  assert_hold_on_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(bck_q) && $stable(lr_q) && $stable(slot_q) && $stable(div_q)));

  // R6: channel flips only together with a bit-clock fall
  assert_lr_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_q != $past(lr_q)) |-> ($past(bck_q) && !bck_q));

  // R1: slot index stays inside the current ratio
  assert_slot_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < nslots);

endmodule

// File: rtl/ser_word.sv
module ser_word
  import ser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              lr,
  input  logic [SLOT_W-1:0] slot,
  input  logic              lsb_first,
  output logic              sdata
);

  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] left_q, right_q, cur;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (load) begin
      left_q  <= in_valid ? in_left  : '0;
      right_q <= in_valid ? in_right : '0;
    end
  end

  always_comb begin
    cur = lr ? right_q : left_q;
    idx = lsb_first ? slot[IDX_W-1:0] : IDX_W'(WORD_W - 1) - slot[IDX_W-1:0];
    sdata = (slot < SLOT_W'(WORD_W)) ? cur[idx] : 1'b0;
  end

  // R8: the load request never lasts two cycles
  assert_single_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

endmodule

// File: rtl/audio_serializer.sv
module audio_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        rate_sel,
  input  logic              wc_invert,
  input  logic              lsb_first,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic              bck,
  output logic              wclk,
  output logic              sdata
);

  ser_cfg_t          cfg_q;
  logic              lr;
  logic [SLOT_W-1:0] slot;
  logic              frame_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{rate: RATE_32, wc_inv: 1'b0, lsb_first: 1'b0};
    end else if (frame_last) begin
      cfg_q <= '{rate: rate_e'(rate_sel), wc_inv: wc_invert, lsb_first: lsb_first};
    end
  end

  ser_timing u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .rate       (cfg_q.rate),
    .bck        (bck),
    .lr         (lr),
    .slot       (slot),
    .frame_last (frame_last)
  );

  ser_word #(.WORD_W(WORD_W)) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_last),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .lr        (lr),
    .slot      (slot),
    .lsb_first (cfg_q.lsb_first),
    .sdata     (sdata)
  );

  assign in_ready = frame_last;
  assign wclk     = lr ^ cfg_q.wc_inv;

  // R7: configuration is adopted only at the request edge
  assert_cfg_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> $past(in_ready));

endmodule

// File: tb/sim_audio_serializer.sv
module sim_audio_serializer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [1:0]  rate_sel = 2'd2;
  logic        wc_invert = 1'b1;
  logic        lsb_first = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = 16'h0;
  logic [15:0] in_right = 16'h0;
  logic        bck, wclk, sdata;

  audio_serializer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
    .wc_invert(wc_invert), .lsb_first(lsb_first), .in_valid(in_valid),
    .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .bck(bck), .wclk(wclk), .sdata(sdata)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int fn       = 0;
  bit running  = 0;
  bit finished = 0;

  // expectation for the frame in progress
  logic [15:0] cur_l = 0, cur_r = 0;
  int          cur_rate = 0;
  logic        cur_pol = 0, cur_lsb = 0;

  logic rec_bit [64];
  logic rec_wc  [64];
  int   rise_cnt = 0, hi_ticks = 0, h_exp = 6, frame_ticks = 0;
  logic pb = 0, pw = 0, ps = 0, prdy = 0, last_tick = 1;

  function automatic int phase_of(int r);
    return (r == 1) ? 4 : (r == 2) ? 3 : 6;
  endfunction
  function automatic int slots_of(int r);
    return (r == 1) ? 24 : (r == 2) ? 32 : 16;
  endfunction
  function automatic logic exp_bit(logic [15:0] l, logic [15:0] r, logic lsb, int k, int i);
    int s = i % k;
    logic [15:0] w = (i >= k) ? r : l;
    if (s >= 16) return 1'b0;
    return lsb ? w[s] : w[15 - s];
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s frame %0d: actual %0d expected %0d", req, fn, act, expv);
    end
  endtask

  task automatic judge_frame();
    int k = slots_of(cur_rate);
    int bad = -1;
    int badw = -1;
    chk(rise_cnt == 2 * k, (fn == 0) ? "R2/R1 slot count" : "R1 slot count", rise_cnt, 2 * k);
    for (int i = 0; i < 2 * k && i < 64; i++) begin
      if (bad < 0 && rec_bit[i] !== exp_bit(cur_l, cur_r, cur_lsb, k, i)) bad = i;
      if (badw < 0 && rec_wc[i] !== ((i >= k) ^ cur_pol)) badw = i;
    end
    if (bad >= 0)
      chk(0, (fn == 0) ? "R2 data" : ((bad % k) >= 16) ? "R5 padding" :
             (cur_l == 0 && cur_r == 0) ? "R9 silence" : "R4/R7 data bit",
          rec_bit[bad], exp_bit(cur_l, cur_r, cur_lsb, k, bad));
    else chk(1, "R4", 0, 0);
    if (badw >= 0) chk(0, "R3 word clock", rec_wc[badw], (badw >= k) ^ cur_pol);
    else chk(1, "R3", 0, 0);
  endtask

  // stimulus and monitor, all away from the rising edge
  always @(negedge clk) begin
    if (running && !finished) begin
      if (fn >= 20 && fn < 28) tick_en = ($urandom % 3) != 0;
      else tick_en = 1'b1;
      case (fn)
        0: {rate_sel, wc_invert, lsb_first} = {2'd2, 1'b1, 1'b1};
        1: {rate_sel, wc_invert, lsb_first} = {2'd1, 1'b0, 1'b0};
        2: {rate_sel, wc_invert, lsb_first} = {2'd2, 1'b1, 1'b0};
        3: {rate_sel, wc_invert, lsb_first} = {2'd3, 1'b0, 1'b1};
        4: {rate_sel, wc_invert, lsb_first} = {2'd0, 1'b1, 1'b1};
        5: {rate_sel, wc_invert, lsb_first} = {2'd2, 1'b0, 1'b1};
        default: if ($urandom % 150 == 0) {rate_sel, wc_invert, lsb_first} = 4'($urandom);
      endcase
      in_valid = (fn == 3 || fn == 10) ? 1'b0 : (($urandom % 5) != 0);
      if (fn == 4) begin
        in_left = 16'h8001; in_right = 16'h7FFE;
      end else begin
        in_left = 16'($urandom); in_right = 16'($urandom);
      end
      #1;
      // R10: nothing moves after an edge without a strobe
      if (!last_tick)
        chk(bck == pb && wclk == pw && sdata == ps, "R10 hold", {bck, wclk, sdata}, {pb, pw, ps});
      // R6: data and word clock move only with a bit-clock fall
      if (sdata != ps || wclk != pw)
        chk(pb && !bck, "R6 change edge", {pb, bck}, 2);
      if (bck && !pb) begin
        if (rise_cnt < 64) begin
          rec_bit[rise_cnt] = sdata;
          rec_wc[rise_cnt]  = wclk;
        end
        rise_cnt++;
        hi_ticks = 0;
        h_exp = phase_of(cur_rate);
      end
      if (bck) hi_ticks += int'(tick_en);
      if (!bck && pb) chk(hi_ticks == h_exp, "R1 phase length", hi_ticks, h_exp);
      frame_ticks += int'(tick_en);
      if (in_ready) begin
        chk(!prdy, "R8 single cycle", prdy, 0);
        chk(frame_ticks == 384, "R8 frame length", frame_ticks, 384);
        frame_ticks = 0;
        judge_frame();
        cur_l    = in_valid ? in_left  : 16'h0;
        cur_r    = in_valid ? in_right : 16'h0;
        cur_rate = int'(rate_sel);
        cur_pol  = wc_invert;
        cur_lsb  = lsb_first;
        rise_cnt = 0;
        fn++;
      end
      pb = bck; pw = wclk; ps = sdata; prdy = in_ready; last_tick = tick_en;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(bck == 0 && wclk == 0 && sdata == 0 && in_ready == 0, "R2 reset outputs",
        {bck, wclk, sdata, in_ready}, 0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    #2;
    chk(bck == 0 && wclk == 0 && sdata == 0, "R2 after reset", {bck, wclk, sdata}, 0);
    wait (fn >= 40);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d frames expected 40", fn);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule